// File: doc/BRIEF.md
# Prescaled Countdown Timer with Free-Running Counter

This block holds two counters behind one 32-bit register port. The first is a countdown timer. Software writes a start value, and the value then falls by one on every prescaled tick. On the tick that finds it at zero, the timer sets an interrupt flag and reloads itself from a separate reload register. The tick rate is the system clock divided first by a programmable predivider and then by a selectable factor of 1, 16 or 256. The counter can run in 16-bit or 32-bit width, and a debug-halt input can freeze it when software allows this.

The second counter is a 32-bit up-counter that runs on its own. It has an 8-bit prescale value and its own enable, and software can read it at any time. Neither the countdown timer's enable nor the debug-halt input affects it. One control word holds the settings of both counters. The interrupt output is the raw flag gated by the interrupt enable.

Top module: `tick_timer`

## Requirements
- R1: After reset, every readable word reads 0 and `irq` is low.
- R2: Word indexes are: 0 load, 1 current value, 2 control, 3 acknowledge, 4 raw flag (bit 0), 5 masked flag (bit 0), 6 reload, 7 predivider (10 bits), 8 free count. The control word reads back only its defined bits, so writing all ones reads 0x00FF03AE. Word 3 and unused indexes 9 to 15 read 0.
- R3: Writing word 0 sets both the current value and the reload value to the written data, and restarts the prescaler. Each later tick lowers the value by one.
- R4: A tick that finds the value at zero sets the raw flag and copies the reload value into the current value. After a load of N, this happens on tick N+1. Writing word 6 changes only the reload value and leaves the running count alone.
- R5: The tick period is (P+1)×S clock cycles. P is word 7. S comes from control bits 3:2: code 0 gives 1, code 1 gives 16, and codes 2 and 3 give 256.
- R6: With control bit 1 clear (16-bit width), only bits 15:0 count down. Zero is detected on those 16 bits, and bits 31:16 keep their value.
- R7: With control bit 7 (timer enable) clear, the current value does not change.
- R8: The masked flag and `irq` equal the raw flag AND control bit 5. The raw flag is set whatever the value of bit 5.
- R9: Any write to word 3 clears the raw flag. If a zero-tick falls in the same cycle, the flag stays set.
- R10: While control bit 8 is set and `dbg_halt` is high, the countdown and its prescaler stop. With bit 8 clear, `dbg_halt` has no effect.
- R11: With control bit 9 set, the free count rises by one every F+1 cycles, where F is control bits 23:16. Neither `dbg_halt` nor bit 7 affects it. With bit 9 clear, the free count holds its value.
- R12: Writes to word 8 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by `bus_sel` |
| bus_addr | input | 4 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| dbg_halt | input | 1 | Debug halt request |
| irq | output | 1 | Masked timer interrupt |

## Verification
The case hardest to reach from the ports is an acknowledge write that lands on the very cycle a zero-tick sets the flag. The bench reaches it by loading zero at a divide-by-one rate, so every cycle is a zero-tick. An acknowledge write then cannot miss the collision. The bench also stages each count test with the timer disabled: it loads, acknowledges and only then enables. The count therefore starts at an exactly known edge, and long divide-by-256 waits can be predicted to the cycle.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned STAGE_W = 8;
  localparam int unsigned FRS_W   = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_LOAD   = 4'd0,
    A_VALUE  = 4'd1,
    A_CTRL   = 4'd2,
    A_ACK    = 4'd3,
    A_RAW    = 4'd4,
    A_MASKED = 4'd5,
    A_RELOAD = 4'd6,
    A_PREDIV = 4'd7,
    A_FREE   = 4'd8
  } reg_addr_e;

  localparam int unsigned B_WIDE    = 1;
  localparam int unsigned B_PSEL_LO = 2;
  localparam int unsigned B_IRQ_EN  = 5;
  localparam int unsigned B_TMR_EN  = 7;
  localparam int unsigned B_HALT_EN = 8;
  localparam int unsigned B_FR_EN   = 9;
  localparam int unsigned B_FRS_LO  = 16;

  typedef struct packed {
    logic [FRS_W-1:0] fr_scale;
    logic             fr_en;
    logic             halt_en;
    logic             tmr_en;
    logic             irq_en;
    logic [1:0]       psel;
    logic             wide;
  } ctrl_t;

  function automatic logic [STAGE_W-1:0] stage_mask(input logic [1:0] sel);
    case (sel)
      2'd0:    return '0;
      2'd1:    return STAGE_W'(8'h0F);
      default: return STAGE_W'(8'hFF);
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[B_WIDE]                    = c.wide;
    w[B_PSEL_LO +: 2]            = c.psel;
    w[B_IRQ_EN]                  = c.irq_en;
    w[B_TMR_EN]                  = c.tmr_en;
    w[B_HALT_EN]                 = c.halt_en;
    w[B_FR_EN]                   = c.fr_en;
    w[B_FRS_LO +: FRS_W]         = c.fr_scale;
    return w;
  endfunction

  function automatic ctrl_t unpack_ctrl(input logic [DATA_W-1:0] w);
    ctrl_t c;
    c.wide     = w[B_WIDE];
    c.psel     = w[B_PSEL_LO +: 2];
    c.irq_en   = w[B_IRQ_EN];
    c.tmr_en   = w[B_TMR_EN];
    c.halt_en  = w[B_HALT_EN];
    c.fr_en    = w[B_FR_EN];
    c.fr_scale = w[B_FRS_LO +: FRS_W];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] next_down(input logic [DATA_W-1:0] v,
                                                  input logic [DATA_W-1:0] rl,
                                                  input logic wide);
    if (wide) return (v == '0) ? rl : v - 1'b1;
    return (v[15:0] == 16'd0) ? {v[DATA_W-1:16], rl[15:0]}
                              : {v[DATA_W-1:16], v[15:0] - 16'd1};
  endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import tick_timer_pkg::*;
#(
  parameter int unsigned PREDIV_W = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic                run,
  input  logic [PREDIV_W-1:0] prediv,
  input  logic [1:0]          psel,
  output logic                tick
);

  logic [PREDIV_W-1:0] pre_q;
  logic [STAGE_W-1:0]  stage_q;
  logic [STAGE_W-1:0]  mask;
  logic                base_hit;
  logic                stage_hit;

  assign mask      = stage_mask(psel);
  assign base_hit  = (pre_q >= prediv);
  assign stage_hit = ((stage_q & mask) == mask);
  assign tick      = run & base_hit & stage_hit;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      pre_q   <= '0;
      stage_q <= '0;
    end else if (run) begin
      if (base_hit) begin
        pre_q   <= '0;
        stage_q <= stage_hit ? '0 : stage_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  // R10: a stopped prescaler keeps its state
  a_r10_prescaler_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> ($stable(pre_q) && $stable(stage_q)));

endmodule

// File: rtl/tick_countdown.sv
module tick_countdown
  import tick_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_wr,
  input  logic              reload_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  input  logic              wide,
  input  logic              ack_wr,
  output logic [DATA_W-1:0] value,
  output logic [DATA_W-1:0] reload,
  output logic              raw,
  output logic              underflow
);

  logic at_zero;

  assign at_zero   = wide ? (value == '0) : (value[15:0] == 16'd0);
  assign underflow = tick & at_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value  <= '0;
      reload <= '0;
    end else if (load_wr) begin
      value  <= wdata;
      reload <= wdata;
    end else begin
      if (reload_wr) reload <= wdata;
      if (tick)      value  <= next_down(value, reload, wide);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         raw <= 1'b0;
    else if (underflow) raw <= 1'b1;
    else if (ack_wr)    raw <= 1'b0;
  end

  a_r4_zero_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> raw);

  a_r9_ack_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !underflow) |=> !raw);

  a_r7_no_tick_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_wr) |=> $stable(value));

  a_r6_upper_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide && !load_wr) |=> $stable(value[DATA_W-1:16]));

endmodule

// File: rtl/tick_freerun.sv
module tick_freerun
  import tick_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [FRS_W-1:0]  scale,
  output logic [DATA_W-1:0] count
);

  logic [FRS_W-1:0] pre_q;
  logic             step;

  assign step = en & (pre_q >= scale);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
      count <= '0;
    end else if (en) begin
      if (step) begin
        pre_q <= '0;
        count <= count + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  a_r11_single_steps: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count == $past(count) || count == $past(count) + 32'd1));

  a_r11_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(count));

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned PREDIV_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              dbg_halt,
  output logic              irq
);

  ctrl_t               ctrl_q;
  logic [PREDIV_W-1:0] prediv_q;
  logic                wr_en;
  logic                load_wr;
  logic                reload_wr;
  logic                ctrl_wr;
  logic                ack_wr;
  logic                prediv_wr;
  logic                halted;
  logic                cd_run;
  logic                cd_tick;
  logic                underflow;
  logic                raw;
  logic [DATA_W-1:0]   cd_value;
  logic [DATA_W-1:0]   cd_reload;
  logic [DATA_W-1:0]   fr_count;

  assign wr_en     = bus_sel & bus_wr;
  assign load_wr   = wr_en && (bus_addr == A_LOAD);
  assign ctrl_wr   = wr_en && (bus_addr == A_CTRL);
  assign ack_wr    = wr_en && (bus_addr == A_ACK);
  assign reload_wr = wr_en && (bus_addr == A_RELOAD);
  assign prediv_wr = wr_en && (bus_addr == A_PREDIV);

  assign halted = ctrl_q.halt_en & dbg_halt;
  assign cd_run = ctrl_q.tmr_en & ~halted;
  assign irq    = raw & ctrl_q.irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      prediv_q <= '0;
    end else begin
      if (ctrl_wr)   ctrl_q   <= unpack_ctrl(bus_wdata);
      if (prediv_wr) prediv_q <= bus_wdata[PREDIV_W-1:0];
    end
  end

  tick_prescaler #(.PREDIV_W(PREDIV_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (load_wr),
    .run     (cd_run),
    .prediv  (prediv_q),
    .psel    (ctrl_q.psel),
    .tick    (cd_tick)
  );

  tick_countdown u_cd (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_wr   (load_wr),
    .reload_wr (reload_wr),
    .wdata     (bus_wdata),
    .tick      (cd_tick),
    .wide      (ctrl_q.wide),
    .ack_wr    (ack_wr),
    .value     (cd_value),
    .reload    (cd_reload),
    .raw       (raw),
    .underflow (underflow)
  );

  tick_freerun u_fr (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (ctrl_q.fr_en),
    .scale (ctrl_q.fr_scale),
    .count (fr_count)
  );

  always_comb begin
    case (bus_addr)
      A_LOAD, A_RELOAD: bus_rdata = cd_reload;
      A_VALUE:          bus_rdata = cd_value;
      A_CTRL:           bus_rdata = pack_ctrl(ctrl_q);
      A_RAW:            bus_rdata = {{(DATA_W-1){1'b0}}, raw};
      A_MASKED:         bus_rdata = {{(DATA_W-1){1'b0}}, irq};
      A_PREDIV:         bus_rdata = DATA_W'(prediv_q);
      A_FREE:           bus_rdata = fr_count;
      default:          bus_rdata = '0;
    endcase
  end

  a_r10_halt_freezes_value: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !load_wr) |=> $stable(cd_value));

  a_r8_irq_implies_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> raw);

  a_r4_zero_tick_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && ctrl_q.wide && !load_wr) |=> (cd_value == $past(cd_reload)));

endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  typedef struct packed {
    logic [1:0]  psel;
    logic [9:0]  prediv;
    logic [31:0] load;
    logic [15:0] wait_cyc;
    logic [31:0] exp_val;
    logic        exp_raw;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 10'd0,  32'd10,  16'd4,   32'd6,  1'b0},
    '{2'd0, 10'd0,  32'd3,   16'd4,   32'd3,  1'b1},
    '{2'd1, 10'd0,  32'd5,   16'd40,  32'd3,  1'b0},
    '{2'd2, 10'd0,  32'd1,   16'd600, 32'd1,  1'b1},
    '{2'd0, 10'd3,  32'd100, 16'd50,  32'd88, 1'b0},
    '{2'd1, 10'd1,  32'd2,   16'd100, 32'd2,  1'b1},
    '{2'd3, 10'd0,  32'd7,   16'd300, 32'd6,  1'b0},
    '{2'd0, 10'd0,  32'd0,   16'd5,   32'd0,  1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        dbg_halt = 1'b0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  tick_timer u_tick_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .dbg_halt  (dbg_halt),
    .irq       (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // control word: wide bit1, psel 3:2, irq_en 5, tmr_en 7, halt_en 8, fr_en 9, scale 23:16
  function automatic logic [31:0] cw(input bit wide, input logic [1:0] ps, input bit ie,
                                     input bit te, input bit he, input bit fe,
                                     input logic [7:0] fs);
    return {8'd0, fs, 6'd0, fe, he, te, 1'b0, ie, 1'b0, ps, wide, 1'b0};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, c1;
    cycles(3);
    rst_n = 1'b1;
    cycles(1);

    // R1: reset state
    for (int a = 0; a < 9; a++) begin
      rd(4'(a), r);
      check("R1", $sformatf("word %0d after reset", a), r, 32'd0);
    end
    check("R1", "irq after reset", {31'd0, irq}, 32'd0);

    // R11 free-running count with halt asserted and timer disabled
    dbg_halt = 1'b1;
    wr(4'd2, cw(0, 2'd0, 0, 0, 1, 1, 8'd3));
    cycles(20);
    rd(4'd8, r);
    check("R11", "free count after 20 cycles, scale 3", r, 32'd5);
    dbg_halt = 1'b0;
    wr(4'd2, 32'd0);
    rd(4'd8, c1);
    cycles(10);
    rd(4'd8, r);
    check("R11", "free count holds when disabled", r, c1);
    // R12
    wr(4'd8, 32'hDEAD_BEEF);
    rd(4'd8, r);
    check("R12", "free count write ignored", r, c1);

    // R2: control readback and unused words
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd2, r);
    check("R2", "control readback mask", r, 32'h00FF_03AE);
    wr(4'd2, 32'd0);
    rd(4'd3, r);
    check("R2", "ack word reads 0", r, 32'd0);
    wr(4'd12, 32'h1234_5678);
    rd(4'd12, r);
    check("R2", "unused word reads 0", r, 32'd0);
    wr(4'd7, 32'hFFFF_FFFF);
    rd(4'd7, r);
    check("R2", "predivider width 10 bits", r, 32'h0000_03FF);

    // vector table: R3 R4 R5 R8
    for (int i = 0; i < NVEC; i++) begin
      wr(4'd2, cw(1, VECS[i].psel, 1, 0, 0, 0, 8'd0));
      wr(4'd7, {22'd0, VECS[i].prediv});
      wr(4'd0, VECS[i].load);
      wr(4'd3, 32'd0);
      rd(4'd0, r);
      check("R3", $sformatf("vec %0d load readback", i), r, VECS[i].load);
      wr(4'd2, cw(1, VECS[i].psel, 1, 1, 0, 0, 8'd0));
      cycles(int'(VECS[i].wait_cyc));
      rd(4'd1, r);
      check("R5", $sformatf("vec %0d value", i), r, VECS[i].exp_val);
      rd(4'd4, r);
      check("R4", $sformatf("vec %0d raw flag", i), r, {31'd0, VECS[i].exp_raw});
      check("R8", $sformatf("vec %0d irq", i), {31'd0, irq}, {31'd0, VECS[i].exp_raw});
    end

    // R4: reload write does not disturb running count, then used on zero tick
    wr(4'd2, cw(1, 2'd0, 1, 0, 0, 0, 8'd0));
    wr(4'd7, 32'd0);
    wr(4'd0, 32'd5);
    wr(4'd3, 32'd0);
    wr(4'd6, 32'd2);
    rd(4'd1, r);
    check("R4", "reload write leaves value", r, 32'd5);
    wr(4'd2, cw(1, 2'd0, 1, 1, 0, 0, 8'd0));
    cycles(6);
    rd(4'd1, r);
    check("R4", "value takes reload on zero tick", r, 32'd2);
    rd(4'd4, r);
    check("R4", "raw set on zero tick", r, 32'd1);

    // R6: 16-bit width
    wr(4'd2, cw(0, 2'd0, 1, 0, 0, 0, 8'd0));
    wr(4'd0, 32'h0001_0002);
    wr(4'd3, 32'd0);
    wr(4'd2, cw(0, 2'd0, 1, 1, 0, 0, 8'd0));
    cycles(2);
    rd(4'd1, r);
    check("R6", "16-bit low half at zero", r, 32'h0001_0000);
    rd(4'd4, r);
    check("R6", "no flag before 16-bit zero tick", r, 32'd0);
    cycles(1);
    rd(4'd1, r);
    check("R6", "16-bit reload keeps upper half", r, 32'h0001_0002);
    rd(4'd4, r);
    check("R6", "flag at 16-bit zero", r, 32'd1);

    // R7: timer enable clear
    wr(4'd2, cw(1, 2'd0, 1, 0, 0, 0, 8'd0));
    wr(4'd0, 32'd9);
    cycles(10);
    rd(4'd1, r);
    check("R7", "disabled timer holds", r, 32'd9);

    // R8: interrupt enable clear
    wr(4'd3, 32'd0);
    wr(4'd0, 32'd0);
    wr(4'd2, cw(1, 2'd0, 0, 1, 0, 0, 8'd0));
    cycles(3);
    rd(4'd4, r);
    check("R8", "raw set with irq disabled", r, 32'd1);
    rd(4'd5, r);
    check("R8", "masked clear with irq disabled", r, 32'd0);
    check("R8", "irq low with irq disabled", {31'd0, irq}, 32'd0);
    wr(4'd2, cw(1, 2'd0, 1, 1, 0, 0, 8'd0));
    rd(4'd5, r);
    check("R8", "masked follows enable", r, 32'd1);
    check("R8", "irq follows enable", {31'd0, irq}, 32'd1);

    // R9: ack colliding with zero tick (load 0 ticks zero every cycle)
    wr(4'd3, 32'd0);
    rd(4'd4, r);
    check("R9", "zero tick wins over ack", r, 32'd1);
    wr(4'd2, cw(1, 2'd0, 1, 0, 0, 0, 8'd0));
    wr(4'd3, 32'h5A5A_5A5A);
    rd(4'd4, r);
    check("R9", "ack clears raw", r, 32'd0);
    check("R9", "ack drops irq", {31'd0, irq}, 32'd0);

    // R10: debug halt
    wr(4'd0, 32'd50);
    dbg_halt = 1'b1;
    wr(4'd2, cw(1, 2'd0, 1, 1, 1, 0, 8'd0));
    cycles(10);
    rd(4'd1, r);
    check("R10", "halted countdown frozen", r, 32'd50);
    dbg_halt = 1'b0;
    cycles(5);
    rd(4'd1, r);
    check("R10", "counts after halt released", r, 32'd45);
    dbg_halt = 1'b1;
    wr(4'd2, cw(1, 2'd0, 1, 1, 0, 0, 8'd0));
    cycles(4);
    rd(4'd1, r);
    check("R10", "halt ignored without halt enable", r, 32'd41);
    dbg_halt = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule